// File: doc/BRIEF.md
# Segment Relocation and Limit Checker

This block turns effective addresses into physical addresses with a pair of segment registers for each access type. An access is either an instruction fetch or a data load/store. The access type picks a segment: fetches use the program segment and data accesses use the data segment. The block compares the effective address with that segment's limit. If the address is inside the segment, the block adds the segment's base to form the physical address. If the address is outside, the block reports a limit fault and does not give an address.

The comparison and the addition are combinational. Their results are captured in registers, so the outcome appears one clock after the access is presented. The segment registers can be written and read back through a small configuration port. That port works only while the supervisor-mode input is high. A write attempted in user mode changes nothing and produces a one-cycle privilege-fault pulse. After reset every base and every limit is zero, so all accesses fault until supervisor code sets the segments up.

Top module: `seg_reloc_unit`

## Requirements
- R1: An access with `acc_kind_i` = 0 (fetch) and effective address below the program limit produces `pa_valid_o` = 1 and `pa_o` = program base + address, one cycle later.
- R2: An access with `acc_kind_i` = 1 (data) and effective address below the data limit produces `pa_valid_o` = 1 and `pa_o` = data base + address, one cycle later.
- R3: An access whose effective address is greater than or equal to the selected limit produces `lim_fault_o` = 1, `pa_valid_o` = 0 and `pa_o` = 0, one cycle later.
- R4: Each result appears exactly one cycle after `acc_valid_i` is sampled high. In any cycle that follows no access, `pa_valid_o`, `lim_fault_o` and `pa_o` are all 0. `pa_valid_o` and `lim_fault_o` are never high together.
- R5: When `cfg_we_i` = 1 and `sup_mode_i` = 1, the register named by `cfg_seg_i` (0 program, 1 data) and `cfg_lim_i` (0 base, 1 limit) takes `cfg_wdata_i` at the clock edge.
- R6: When `cfg_we_i` = 1 and `sup_mode_i` = 0, no register changes, and `priv_fault_o` is 1 for exactly the following cycle. In all other cases `priv_fault_o` is 0.
- R7: `cfg_rdata_o` shows the register selected by `cfg_seg_i`/`cfg_lim_i` combinationally while `sup_mode_i` = 1. It reads 0 while `sup_mode_i` = 0.
- R8: After reset all four registers are 0, so every access faults.
- R9: An access in the same cycle as a register write is translated with the register contents from before that write.
- R10: The physical address is the sum modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid_i | input | 1 | Access present this cycle |
| acc_kind_i | input | 1 | 0 instruction fetch, 1 data access |
| acc_addr_i | input | AW | Effective address |
| sup_mode_i | input | 1 | Supervisor mode |
| cfg_we_i | input | 1 | Register write request |
| cfg_seg_i | input | 1 | Register segment select (0 program, 1 data) |
| cfg_lim_i | input | 1 | Register field select (0 base, 1 limit) |
| cfg_wdata_i | input | AW | Register write data |
| cfg_rdata_o | output | AW | Register read data (0 in user mode) |
| pa_valid_o | output | 1 | Registered physical address valid |
| pa_o | output | AW | Registered physical address |
| lim_fault_o | output | 1 | Registered limit fault |
| priv_fault_o | output | 1 | Pulse after a user-mode write attempt |

## Verification
The assertions assume that `acc_kind_i`, `cfg_seg_i` and `cfg_lim_i` are always 0 or 1. The bench never drives X or Z on these inputs. The assertions also assume that configuration and access inputs are stable at the active edge. The bench drives every input on the falling edge, so this holds. The random stimulus draws limits and addresses from overlapping small ranges, so in-range and out-of-range accesses both occur often. Write attempts are spread over both privilege modes.

// File: rtl/seg_reloc_pkg.sv
package seg_reloc_pkg;
  localparam int NSEG     = 2;
  localparam int SEG_PROG = 0;
  localparam int SEG_DATA = 1;
  typedef enum logic {
    ACC_FETCH = 1'b0,
    ACC_DATA  = 1'b1
  } acc_kind_e;
endpackage

// File: rtl/seg_rst_sync.sv
module seg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/seg_regfile.sv
module seg_regfile #(
  parameter int AW   = 32,
  parameter int NSEG = 2,
  localparam int SW  = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sup_i,
  input  logic          we_i,
  input  logic [SW-1:0] seg_i,
  input  logic          lim_i,
  input  logic [AW-1:0] wdata_i,
  input  logic [SW-1:0] acc_seg_i,
  output logic [AW-1:0] acc_base_o,
  output logic [AW-1:0] acc_lim_o,
  output logic [AW-1:0] rdata_o,
  output logic          priv_fault_o
);
  logic [NSEG-1:0][AW-1:0] base_all;
  logic [NSEG-1:0][AW-1:0] lim_all;
  logic                    wr_ok;
  logic                    priv_d;
  logic                    priv_q;

  assign wr_ok = we_i && sup_i;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    logic          base_en;
    logic          lim_en;
    logic [AW-1:0] base_q;
    logic [AW-1:0] lim_q;

    always_comb begin
      base_en = wr_ok && (seg_i == SW'(g)) && !lim_i;
      lim_en  = wr_ok && (seg_i == SW'(g)) &&  lim_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       base_q <= '0;
      else if (base_en) base_q <= wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lim_q <= '0;
      else if (lim_en) lim_q <= wdata_i;
    end

    assign base_all[g] = base_q;
    assign lim_all[g]  = lim_q;
  end

  always_comb begin
    acc_base_o = base_all[acc_seg_i];
    acc_lim_o  = lim_all[acc_seg_i];
    rdata_o    = '0;
    if (sup_i) rdata_o = lim_i ? lim_all[seg_i] : base_all[seg_i];
  end

  always_comb priv_d = we_i && !sup_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) priv_q <= 1'b0;
    else        priv_q <= priv_d;
  end

  assign priv_fault_o = priv_q;

  // R6
  user_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !sup_i) |=> ($stable(base_all) && $stable(lim_all)));

  // R6
  priv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !sup_i) |=> priv_fault_o);

  // R6
  priv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_i && !sup_i) |=> !priv_fault_o);

  // R7
  user_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_i |-> (rdata_o == '0));
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid_i,
  input  logic [AW-1:0] ea_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] lim_i,
  output logic          pa_valid_o,
  output logic [AW-1:0] pa_o,
  output logic          fault_o
);
  logic          in_range;
  logic [AW-1:0] sum;
  logic          valid_d, valid_q;
  logic          fault_d, fault_q;
  logic [AW-1:0] pa_d, pa_q;

  always_comb begin
    in_range = ea_i < lim_i;
    sum      = base_i + ea_i;
    valid_d  = acc_valid_i &&  in_range;
    fault_d  = acc_valid_i && !in_range;
    pa_d     = valid_d ? sum : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      fault_q <= 1'b0;
      pa_q    <= '0;
    end else begin
      valid_q <= valid_d;
      fault_q <= fault_d;
      pa_q    <= pa_d;
    end
  end

  assign pa_valid_o = valid_q;
  assign fault_o    = fault_q;
  assign pa_o       = pa_q;

  // R4
  excl_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pa_valid_o && fault_o));

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid_i |=> (!pa_valid_o && !fault_o && pa_o == '0));

  // R4
  one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid_i |=> (pa_valid_o || fault_o));

  // R3
  fault_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (pa_o == '0));
endmodule

// File: rtl/seg_reloc_unit.sv
module seg_reloc_unit
  import seg_reloc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid_i,
  input  logic          acc_kind_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic          sup_mode_i,
  input  logic          cfg_we_i,
  input  logic          cfg_seg_i,
  input  logic          cfg_lim_i,
  input  logic [AW-1:0] cfg_wdata_i,
  output logic [AW-1:0] cfg_rdata_o,
  output logic          pa_valid_o,
  output logic [AW-1:0] pa_o,
  output logic          lim_fault_o,
  output logic          priv_fault_o
);
  logic          rst_core_n;
  logic          acc_seg;
  logic [AW-1:0] sel_base;
  logic [AW-1:0] sel_lim;

  seg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  always_comb acc_seg = (acc_kind_e'(acc_kind_i) == ACC_DATA) ? 1'(SEG_DATA) : 1'(SEG_PROG);

  seg_regfile #(.AW(AW), .NSEG(NSEG)) u_regs (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .sup_i        (sup_mode_i),
    .we_i         (cfg_we_i),
    .seg_i        (cfg_seg_i),
    .lim_i        (cfg_lim_i),
    .wdata_i      (cfg_wdata_i),
    .acc_seg_i    (acc_seg),
    .acc_base_o   (sel_base),
    .acc_lim_o    (sel_lim),
    .rdata_o      (cfg_rdata_o),
    .priv_fault_o (priv_fault_o)
  );

  seg_xlate #(.AW(AW)) u_xlate (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .acc_valid_i (acc_valid_i),
    .ea_i        (acc_addr_i),
    .base_i      (sel_base),
    .lim_i       (sel_lim),
    .pa_valid_o  (pa_valid_o),
    .pa_o        (pa_o),
    .fault_o     (lim_fault_o)
  );
endmodule

// File: tb/seg_reloc_unit_tb.sv
module seg_reloc_unit_tb_top;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_valid_i = 1'b0;
  logic          acc_kind_i = 1'b0;
  logic [AW-1:0] acc_addr_i = '0;
  logic          sup_mode_i = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic          cfg_seg_i = 1'b0;
  logic          cfg_lim_i = 1'b0;
  logic [AW-1:0] cfg_wdata_i = '0;
  logic [AW-1:0] cfg_rdata_o;
  logic          pa_valid_o;
  logic [AW-1:0] pa_o;
  logic          lim_fault_o;
  logic          priv_fault_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [AW-1:0] m_base [2];
  logic [AW-1:0] m_lim  [2];

  always #2 clk = ~clk;

  seg_reloc_unit #(.AW(AW)) dut_i (.*);

  task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_rd(bit sup, bit seg, bit lim);
    if (!sup) return '0;
    return lim ? m_lim[seg] : m_base[seg];
  endfunction

  task automatic step(bit v, bit kind, logic [AW-1:0] ea, bit sup, bit we,
                      bit seg, bit lim, logic [AW-1:0] wd);
    bit            e_valid, e_fault, e_priv;
    logic [AW-1:0] e_pa;
    string         tag;
    @(negedge clk);
    acc_valid_i = v; acc_kind_i = kind; acc_addr_i = ea;
    sup_mode_i = sup; cfg_we_i = we; cfg_seg_i = seg; cfg_lim_i = lim;
    cfg_wdata_i = wd;
    #1;
    check(sup ? "R7 readback" : "R7 user read zero", cfg_rdata_o, exp_rd(sup, seg, lim));
    e_valid = v && (ea < m_lim[kind]);
    e_fault = v && !(ea < m_lim[kind]);
    e_pa    = e_valid ? m_base[kind] + ea : '0;
    e_priv  = we && !sup;
    if (!v)          tag = "R4 idle";
    else if (e_fault) tag = "R3 limit";
    else              tag = kind ? "R2 data" : "R1 fetch";
    @(posedge clk);
    if (we && sup) begin
      if (lim) m_lim[seg] = wd; else m_base[seg] = wd;
    end
    #1;
    check({tag, " valid"}, AW'(pa_valid_o), AW'(e_valid));
    check({tag, " fault"}, AW'(lim_fault_o), AW'(e_fault));
    check({tag, " pa"}, pa_o, e_pa);
    check("R6 priv pulse", AW'(priv_fault_o), AW'(e_priv));
  endtask

  task automatic wr(bit sup, bit seg, bit lim, logic [AW-1:0] wd);
    step(0, 0, '0, sup, 1, seg, lim, wd);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EC0_0001));
    for (int i = 0; i < 2; i++) begin m_base[i] = '0; m_lim[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R8: reset contents and outputs
    for (int s = 0; s < 2; s++)
      for (int f = 0; f < 2; f++) begin
        step(0, 0, '0, 1, 0, s[0], f[0], '0);
        check("R8 reset reg", cfg_rdata_o, '0);
      end
    // R8: all accesses fault after reset
    step(1, 0, 32'h0, 0, 0, 0, 0, '0);
    step(1, 1, 32'h10, 0, 0, 0, 0, '0);
    // R5: supervisor setup
    wr(1, 0, 0, 32'h0000_1000);
    wr(1, 0, 1, 32'h0000_0100);
    wr(1, 1, 0, 32'h0008_0000);
    wr(1, 1, 1, 32'h0000_0040);
    step(0, 0, '0, 1, 0, 0, 1, '0);
    check("R5 limit written", cfg_rdata_o, 32'h100);
    // R1/R3 boundaries of program segment
    step(1, 0, 32'h0,  0, 0, 0, 0, '0);
    step(1, 0, 32'hFF, 0, 0, 0, 0, '0);
    step(1, 0, 32'h100, 0, 0, 0, 0, '0);
    // R2/R3 data segment picks its own pair
    step(1, 1, 32'h3F, 0, 0, 0, 0, '0);
    step(1, 1, 32'h40, 0, 0, 0, 0, '0);
    step(1, 1, 32'hFF, 0, 0, 0, 0, '0);
    // R6: user write ignored
    wr(0, 0, 1, 32'hFFFF_FFFF);
    step(0, 0, '0, 1, 0, 0, 1, '0);
    check("R6 write ignored", cfg_rdata_o, 32'h100);
    step(1, 0, 32'h200, 0, 0, 0, 0, '0);
    // R9: write and access in same cycle uses old limit
    step(1, 0, 32'h150, 1, 1, 0, 1, 32'h0000_0200);
    step(1, 0, 32'h150, 0, 0, 0, 0, '0);
    // R10: wrap
    wr(1, 1, 0, 32'hFFFF_FF00);
    wr(1, 1, 1, 32'h0000_1000);
    step(1, 1, 32'h10, 0, 0, 0, 0, '0);
    step(1, 1, 32'h200, 0, 0, 0, 0, '0);
    check("R10 wrap", pa_o, 32'h0000_0100);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      int unsigned r = $urandom;
      if (r[2:0] == 3'd0)
        wr(r[3], r[4], r[5], r[5] ? AW'($urandom_range(0, 32'h1_0000)) : AW'($urandom));
      else
        step(r[6], r[7], AW'($urandom_range(0, 32'h1_8000)), r[8], 0, r[9], r[10], '0);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule